// File: doc/BRIEF.md
# SPI Security-Register Read Responder

This block is the target side of a serial peripheral link that answers one command: a sequential read of a 128-byte one-time-programmable security area. The host lowers chip select and shifts in an 8-bit command, a 24-bit start location and sixteen don't-care clocks. After that, every further serial clock moves one bit of stored data out, most significant bit first. The byte location advances after each byte. The low seven location bits roll from 7Fh back to 00h with no gap between the two bytes.

The block runs on a system clock. It detects edges of the serial clock as a sampled input, so serial clock, chip select and serial input must be synchronous to `clk`, and each serial clock level must last at least two `clk` cycles. Input bits are taken on the rising serial edge, and output bits change on the falling serial edge. Both idle levels of the serial clock therefore work (modes 0 and 3). The output is not a bidirectional pin: `miso_oe` tells the pad when to drive `miso`, and a low `miso_oe` stands for high impedance.

The storage is filled through a plain parallel write strobe. That port has no back-pressure: a write is accepted on every `clk` edge where `pl_we` is high, and it is meant for use while chip select is high. The serial side is not a valid/ready stream either: the host's clock alone paces it, so no back-pressure is possible there.

Top module: `spi_otp_reader`

## Requirements
- R1: When `pl_we` is high at a rising `clk` edge, `pl_data` is stored at byte location `pl_addr`, and a later read from that location returns it.
- R2: The first 8 bits after chip select falls form the command, MSB first. Only the value 77h starts a read. Any other value makes the block ignore the rest of the transaction, and `miso_oe` stays low until chip select rises.
- R3: The 24 bits after the command give the start location, MSB first. Only the lowest 7 bits select the byte, and bits 23 to 7 have no effect on the data returned.
- R4: `miso_oe` is low throughout the command, location and 16 dummy clocks.
- R5: The first data bit, bit 7 of the start byte, is driven after the falling serial edge that follows the last dummy rising edge. Each later falling edge presents the next lower bit, so every bit is valid before the rising edge at which the host samples it.
- R6: After the 8th bit of a byte, the next falling edge presents bit 7 of the byte at the next location. Location 7Fh is followed directly by 00h, with no extra clocks.
- R7: Chip select going high drops `miso_oe` in the same `clk` cycle, through combinational logic. This holds at any bit, including in the middle of a data byte.
- R8: Each new chip select assertion starts again at the command phase with a cleared bit count, whatever phase the previous transaction was left in.
- R9: Reads work with the serial clock idling low (mode 0) and idling high (mode 3). A falling edge seen before the first rising edge has no effect.
- R10: After reset `miso_oe` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples all serial inputs |
| rst_n | input | 1 | Asynchronous active-low reset |
| pl_we | input | 1 | Preload write strobe |
| pl_addr | input | 7 | Preload byte location |
| pl_data | input | 8 | Preload byte value |
| cs_n | input | 1 | Active-low chip select |
| sck | input | 1 | Serial clock from the host |
| mosi | input | 1 | Serial input: command, location and dummy bits |
| miso | output | 1 | Serial output data bit |
| miso_oe | output | 1 | Output enable for `miso`; low means high impedance |

## Verification
The bench goes after four corner cases: the wrap from 7Fh to 00h, start locations with the upper 17 location bits set, commands that differ from 77h by a single bit, and chip select released in the command, location, dummy and data phases.

A design that wraps late would return a stale or blank byte at the seam. A design that decodes too many location bits would read past the 128-byte window. A design that does not restart cleanly on the next chip select would misframe the following command, which shows up as shifted data. A design that enables the output one clock early would drive `miso` during the last dummy clock, and one that counts a mode-3 leading falling edge would deliver every data bit one clock early.

// File: rtl/spi_otp_pkg.sv
package spi_otp_pkg;

  typedef enum logic [2:0] {
    PH_OPC,
    PH_ADR,
    PH_DMY,
    PH_DAT,
    PH_IGN
  } phase_t;

  localparam int unsigned BYTE_W = 8;

endpackage

// File: rtl/spi_sck_edges.sv
module spi_sck_edges (
  input  logic clk,
  input  logic rst_n,
  input  logic sck,
  output logic sck_rise,
  output logic sck_fall
);

  logic sck_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sck_q <= 1'b0;
    else        sck_q <= sck;
  end

  assign sck_rise = sck & ~sck_q;
  assign sck_fall = ~sck & sck_q;

endmodule

// File: rtl/otp_store.sv
module otp_store #(
  parameter int unsigned DEPTH = 128,
  parameter int unsigned DW    = 8,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];

endmodule

// File: rtl/spi_otp_seq.sv
module spi_otp_seq
  import spi_otp_pkg::*;
#(
  parameter int unsigned AW         = 7,
  parameter int unsigned OPC_BITS   = 8,
  parameter int unsigned ADDR_BITS  = 24,
  parameter int unsigned DUMMY_CLKS = 16,
  parameter logic [OPC_BITS-1:0] RD_OPCODE = 8'h77,
  localparam int unsigned CW = $clog2(OPC_BITS + ADDR_BITS + DUMMY_CLKS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs_n,
  input  logic          sck_rise,
  input  logic          mosi,
  input  logic          byte_take,
  output phase_t        phase,
  output logic [AW-1:0] rd_addr
);

  logic [CW-1:0]       cnt;
  logic [OPC_BITS-2:0] opc_sr;
  logic [AW-1:0]       addr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase  <= PH_OPC;
      cnt    <= '0;
      opc_sr <= '0;
      addr   <= '0;
    end else if (cs_n) begin
      phase <= PH_OPC;
      cnt   <= '0;
    end else begin
      if (byte_take) addr <= addr + 1'b1;
      if (sck_rise) begin
        unique case (phase)
          PH_OPC: begin
            opc_sr <= {opc_sr[OPC_BITS-3:0], mosi};
            if (cnt == CW'(OPC_BITS - 1)) begin
              cnt   <= '0;
              phase <= ({opc_sr, mosi} == RD_OPCODE) ? PH_ADR : PH_IGN;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          PH_ADR: begin
            addr <= {addr[AW-2:0], mosi};
            if (cnt == CW'(ADDR_BITS - 1)) begin
              cnt   <= '0;
              phase <= PH_DMY;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          PH_DMY: begin
            if (cnt == CW'(DUMMY_CLKS - 1)) begin
              cnt   <= '0;
              phase <= PH_DAT;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign rd_addr = addr;

  // R6: the location after the last byte is the first byte
  a_r6_wrap_seamless: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_take && !cs_n && rd_addr == {AW{1'b1}}) |=> (rd_addr == '0));

  // R8: a fresh chip select always finds the sequencer at the command phase
  a_r8_restart_clean: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_n) |-> (phase == PH_OPC && cnt == '0));

  // R5: the output side only takes bytes once the data phase is reached
  a_r5_take_in_data: assert property (@(posedge clk) disable iff (!rst_n)
    byte_take |-> (phase == PH_DAT));

endmodule

// File: rtl/spi_otp_shifter.sv
module spi_otp_shifter
  import spi_otp_pkg::*;
#(
  parameter int unsigned DW = 8,
  localparam int unsigned BW = $clog2(DW)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs_n,
  input  logic          sck_fall,
  input  phase_t        phase,
  input  logic [DW-1:0] rd_data,
  output logic          byte_take,
  output logic          bit_out,
  output logic          loaded
);

  logic [DW-1:0] sr;
  logic [BW-1:0] bcnt;
  logic          step;

  assign step      = !cs_n && sck_fall && (phase == PH_DAT);
  assign byte_take = step && (bcnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr     <= '0;
      bcnt   <= '0;
      loaded <= 1'b0;
    end else if (cs_n) begin
      bcnt   <= '0;
      loaded <= 1'b0;
    end else if (step) begin
      if (bcnt == '0) begin
        sr     <= rd_data;
        bcnt   <= BW'(DW - 1);
        loaded <= 1'b1;
      end else begin
        sr   <= {sr[DW-2:0], 1'b0};
        bcnt <= bcnt - 1'b1;
      end
    end
  end

  assign bit_out = sr[DW-1];

endmodule

// File: rtl/spi_otp_reader.sv
module spi_otp_reader
  import spi_otp_pkg::*;
#(
  parameter int unsigned MEM_DEPTH  = 128,
  parameter int unsigned OPC_BITS   = 8,
  parameter int unsigned ADDR_BITS  = 24,
  parameter int unsigned DUMMY_CLKS = 16,
  parameter logic [OPC_BITS-1:0] RD_OPCODE = 8'h77,
  localparam int unsigned AW = $clog2(MEM_DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pl_we,
  input  logic [AW-1:0]     pl_addr,
  input  logic [BYTE_W-1:0] pl_data,
  input  logic              cs_n,
  input  logic              sck,
  input  logic              mosi,
  output logic              miso,
  output logic              miso_oe
);

  logic              sck_rise, sck_fall, byte_take, loaded, bit_out;
  phase_t            phase;
  logic [AW-1:0]     rd_addr;
  logic [BYTE_W-1:0] rd_data;

  spi_sck_edges u_edges (
    .clk(clk), .rst_n(rst_n), .sck(sck),
    .sck_rise(sck_rise), .sck_fall(sck_fall)
  );

  spi_otp_seq #(
    .AW(AW), .OPC_BITS(OPC_BITS), .ADDR_BITS(ADDR_BITS),
    .DUMMY_CLKS(DUMMY_CLKS), .RD_OPCODE(RD_OPCODE)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck_rise(sck_rise),
    .mosi(mosi), .byte_take(byte_take), .phase(phase), .rd_addr(rd_addr)
  );

  otp_store #(.DEPTH(MEM_DEPTH), .DW(BYTE_W)) u_store (
    .clk(clk), .we(pl_we), .waddr(pl_addr), .wdata(pl_data),
    .raddr(rd_addr), .rdata(rd_data)
  );

  spi_otp_shifter #(.DW(BYTE_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck_fall(sck_fall),
    .phase(phase), .rd_data(rd_data), .byte_take(byte_take),
    .bit_out(bit_out), .loaded(loaded)
  );

  assign miso_oe = loaded & ~cs_n;
  assign miso    = miso_oe & bit_out;

  // R4: no drive before the data phase
  a_r4_hiz_until_data: assert property (@(posedge clk) disable iff (!rst_n)
    miso_oe |-> (phase == PH_DAT));

  // R2: a rejected command never enables the output
  a_r2_bad_cmd_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_IGN) |-> !miso_oe);

  // R7: release of chip select clears the output state
  a_r7_release_clears: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_n) |=> !loaded);

endmodule

// File: tb/spi_otp_reader_test.sv
module spi_otp_reader_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       pl_we = 1'b0;
  logic [6:0] pl_addr = '0;
  logic [7:0] pl_data = '0;
  logic       cs_n = 1'b1;
  logic       sck = 1'b0;
  logic       mosi = 1'b0;
  logic       miso, miso_oe;

  int unsigned n_vec = 0;
  int unsigned n_bad = 0;
  logic [7:0]  model [128];

  always #4 clk = ~clk;

  spi_otp_reader uut (
    .clk(clk), .rst_n(rst_n), .pl_we(pl_we), .pl_addr(pl_addr),
    .pl_data(pl_data), .cs_n(cs_n), .sck(sck), .mosi(mosi),
    .miso(miso), .miso_oe(miso_oe)
  );

  function automatic logic exp_bit(input logic [23:0] a, input int k);
    int idx = (int'(a[6:0]) + k / 8) % 128;
    return model[idx][7 - (k % 8)];
  endfunction

  task automatic check(input logic act, input logic exp, input string req);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic preload(input logic [6:0] a, input logic [7:0] d);
    @(negedge clk);
    pl_we = 1'b1; pl_addr = a; pl_data = d;
    model[a] = d;
    @(negedge clk);
    pl_we = 1'b0;
  endtask

  task automatic xfer(input logic [7:0] op, input logic [23:0] a,
                      input int ncyc, input bit m3);
    logic [31:0] hdr = {op, a};
    @(negedge clk);
    sck = m3; cs_n = 1'b1;
    @(negedge clk); @(negedge clk);
    cs_n = 1'b0;
    @(negedge clk); @(negedge clk);
    for (int i = 0; i < ncyc; i++) begin
      if (m3) sck = 1'b0;
      mosi = (i < 32) ? hdr[31 - i] : logic'($urandom() & 1);
      @(negedge clk); @(negedge clk);
      if (op == 8'h77 && i >= 48) begin
        check(miso_oe, 1'b1, "R5");
        check(miso, exp_bit(a, i - 48), (i >= 56) ? "R6" : "R5");
      end else if (op != 8'h77) begin
        check(miso_oe, 1'b0, "R2");
      end else begin
        check(miso_oe, 1'b0, "R4");
      end
      sck = 1'b1;
      @(negedge clk); @(negedge clk);
      if (!m3) sck = 1'b0;
    end
    @(negedge clk);
    cs_n = 1'b1;
    #1 check(miso_oe, 1'b0, "R7");
    @(negedge clk);
    sck = 1'b0;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED0077));
    repeat (3) @(negedge clk);
    check(miso_oe, 1'b0, "R10");
    rst_n = 1'b1;
    @(negedge clk);
    check(miso_oe, 1'b0, "R10");

    // R1: fill the store through the preload port
    for (int a = 0; a < 128; a++) preload(7'(a), 8'($urandom()));

    // R5/R6: full sweep crossing the seam
    xfer(8'h77, 24'h000000, 48 + 129 * 8, 1'b0);
    // R6: start just before the seam
    xfer(8'h77, 24'h00007E, 48 + 24, 1'b0);
    // R3: high location bits set
    xfer(8'h77, 24'hABCD85, 48 + 16, 1'b0);
    xfer(8'h77, 24'hFFFFFF, 48 + 16, 1'b0);
    // R2: single-bit neighbours of the read command
    xfer(8'h76, 24'h000010, 48 + 24, 1'b0);
    xfer(8'hF7, 24'h000010, 48 + 24, 1'b0);
    xfer(8'h57, 24'h000010, 48 + 24, 1'b1);
    // R7/R8: aborts in each phase, each followed by a clean read
    xfer(8'h77, 24'h000033, 5, 1'b0);
    xfer(8'h77, 24'h000021, 48 + 8, 1'b0);
    xfer(8'h77, 24'h000021, 20, 1'b0);
    xfer(8'h77, 24'h000040, 48 + 8, 1'b0);
    xfer(8'h77, 24'h000040, 40, 1'b1);
    xfer(8'h77, 24'h000011, 48 + 8, 1'b1);
    xfer(8'h77, 24'h000011, 48 + 13, 1'b0);
    xfer(8'h77, 24'h000012, 48 + 16, 1'b0);
    // R9: mode 3 reads
    xfer(8'h77, 24'h00007F, 48 + 16, 1'b1);
    xfer(8'h77, 24'h000003, 48 + 24, 1'b1);
    // R1: overwrite a byte, then read it back
    preload(7'h2A, 8'hC3);
    xfer(8'h77, 24'h00002A, 48 + 8, 1'b0);

    // Random mix of commands, locations, lengths and modes
    for (int t = 0; t < 40; t++) begin
      logic [7:0]  op;
      logic [23:0] a;
      int          n;
      op = ($urandom() % 4 == 0) ? 8'($urandom()) : 8'h77;
      a  = 24'($urandom());
      n  = 1 + int'($urandom() % 120);
      if (($urandom() % 8) == 0) preload(7'($urandom()), 8'($urandom()));
      xfer(op, a, n, bit'($urandom() & 1));
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule